// File: doc/BRIEF.md
# Fused Exponential-Scale Vector Unit

This block multiplies a vector of floating-point elements by e^x for a scalar, non-positive argument x, without an exponential unit and without a mantissa multiplier. It approximates e^x by a whole power of two, 2^-L. It then applies that factor to every element by subtracting L from the element's biased exponent field. The sign and mantissa fields are left as they are. It is meant for the rescaling step of a streaming softmax-weighted accumulation, where the running partial sums are repeatedly multiplied by e^(m_old - m_new) as the running maximum grows.

The argument x arrives as 16-bit two's-complement fixed point with 10 fraction bits (Q5.10), tagged by a valid bit. The vector holds `LANES` elements, either BF16 (the default) or FP32, chosen by a parameter. The unit is fully pipelined with no backpressure. A new vector can enter on every clock, and each result leaves four clocks after its input with a valid bit that matches. Elements with a zero exponent field are flushed to signed zero. Infinities and NaNs are passed through unchanged. Any element whose exponent would fall to zero or below becomes signed zero.

Top module: `fexm_unit`

## Requirements
- R1: An argument x greater than zero is treated as zero, so the shift L is 0 and normal elements come out unchanged.
- R2: An argument below -15.0 (raw value below -15360) is treated as exactly -15.0, which gives a shift L of 22.
- R3: With xc the clipped argument, the shift is computed as follows. First form t = xc + (xc >>> 1) - (xc >>> 4), using arithmetic shifts on the raw Q5.10 value. Then L = -((t + 512) >>> 10). For an element with biased exponent e, where e is between 1 and 254 and greater than L, the output exponent is e - L, and the sign and mantissa bits are unchanged.
- R4: An element with biased exponent e between 1 and 254 where e <= L (underflow) leaves as its original sign bit, with all exponent and mantissa bits zero.
- R5: An element whose exponent field is all ones (infinity or NaN) leaves bit-for-bit unchanged.
- R6: An element whose exponent field is zero (zero or subnormal) leaves as its original sign bit followed by all-zero bits.
- R7: out_valid equals in_valid from four clocks earlier. Back-to-back inputs produce back-to-back outputs, and each output belongs to the input four clocks before it.
- R8: While reset is held and just after it is released, out_valid is low and out_vec is zero.
- R9: Lane i occupies out_vec and in_vec bits [i*W +: W], where W is 16 for BF16 and 32 for FP32. Within a lane the sign is the MSB, followed by an 8-bit biased exponent and then the mantissa. Each lane is handled on its own, so different rules can apply to different lanes of the same vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat is valid |
| in_x | input | 16 | Argument x, signed Q5.10 |
| in_vec | input | LANES*W | Input vector, lane 0 in the low bits |
| out_valid | output | 1 | Output beat is valid |
| out_vec | output | LANES*W | Scaled vector |

## Verification
Clipping of the argument and per-lane underflow can act on the same beat. A clipped argument yields the largest shift of 22, and at that shift small-exponent lanes drop to signed zero while other lanes of the same vector still scale or pass as specials. Directed beats put an argument far below -15 beside lanes with exponent 22 (underflow) and 23 (which must scale to exactly 1). A further beat at exactly -15.0 holds normal, underflow, zero and infinity lanes together. Random stimulus keeps mixing saturated arguments with lanes of every kind. Each lane is judged against a bench model of the shift and of the exponent rule.

// File: rtl/fexm_pkg.sv
package fexm_pkg;

  localparam int XW        = 16;          // argument width, Q5.10
  localparam int FRAC      = 10;          // fraction bits of the argument
  localparam int TW        = XW + 2;      // width of the base-2 product term
  localparam int SHW       = 5;           // width of the exponent shift
  localparam int EXW       = 8;           // exponent field width (BF16 and FP32)
  localparam int MAX_SHIFT = 22;          // shift produced by the clip floor

  localparam logic signed [XW-1:0] CLIP_LO = -16'sd15360;  // -15.0
  localparam logic signed [TW-1:0] HALF    = TW'(1 << (FRAC - 1));

  typedef enum logic [1:0] {
    EK_NORMAL  = 2'd0,
    EK_UNDER   = 2'd1,
    EK_SPECIAL = 2'd2,
    EK_ZERO    = 2'd3
  } ekind_e;

  // Saturate the argument into [-15, 0].
  function automatic logic signed [XW-1:0] clip_arg(input logic signed [XW-1:0] x);
    if (x > 0)
      return '0;
    else if (x < CLIP_LO)
      return CLIP_LO;
    else
      return x;
  endfunction

  // x * log2(e) approximated as x * (1 + 1/2 - 1/16).
  function automatic logic signed [TW-1:0] log2e_term(input logic signed [XW-1:0] xc);
    logic signed [TW-1:0] w;
    w = {{(TW-XW){xc[XW-1]}}, xc};
    return w + (w >>> 1) - (w >>> 4);
  endfunction

  // Round half up to an integer, then negate to get the exponent shift.
  function automatic logic [SHW-1:0] round_shift(input logic signed [TW-1:0] t);
    logic signed [TW-1:0] r;
    r = (t + HALF) >>> FRAC;
    r = -r;
    return r[SHW-1:0];
  endfunction

  // Decide how a lane is treated from its exponent field and the shift.
  function automatic ekind_e classify(input logic [EXW-1:0] e, input logic [SHW-1:0] sh);
    if (e == {EXW{1'b1}})
      return EK_SPECIAL;
    else if (e == '0)
      return EK_ZERO;
    else if (e <= EXW'(sh))
      return EK_UNDER;
    else
      return EK_NORMAL;
  endfunction

  function automatic logic [EXW-1:0] exp_reduce(input logic [EXW-1:0] e, input logic [SHW-1:0] sh);
    return e - EXW'(sh);
  endfunction

endpackage

// File: rtl/fexm_shift_path.sv
module fexm_shift_path
  import fexm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic signed [XW-1:0]  in_x,
  output logic signed [XW-1:0]  s1_xc,
  output logic                  s3_valid,
  output logic [SHW-1:0]        s3_shift
);

  logic                 s1_valid;
  logic                 s2_valid;
  logic signed [TW-1:0] s2_term;

  // stage 1: clip
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_xc    <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_xc    <= clip_arg(in_x);
    end
  end

  // stage 2: shift-and-add base-2 conversion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_term  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_term  <= log2e_term(s1_xc);
    end
  end

  // stage 3: round to the integer shift
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_valid <= 1'b0;
      s3_shift <= '0;
    end else begin
      s3_valid <= s2_valid;
      s3_shift <= round_shift(s2_term);
    end
  end

endmodule

// File: rtl/fexm_vec_delay.sv
module fexm_vec_delay #(
  parameter int W     = 64,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] pipe [DEPTH+1];

  assign pipe[0] = d_in;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)
        pipe[k+1] <= '0;
      else
        pipe[k+1] <= pipe[k];
    end
  end

  assign d_out = pipe[DEPTH];

endmodule

// File: rtl/fexm_lane.sv
module fexm_lane
  import fexm_pkg::*;
#(
  parameter int EW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EW-1:0]  elem_in,
  input  logic [SHW-1:0] shift,
  output logic           is_under,
  output logic           is_special,
  output logic [EW-1:0]  elem_out
);

  localparam int MW = EW - 1 - EXW;

  logic           sgn;
  logic [EXW-1:0] expo;
  logic [MW-1:0]  mant;
  ekind_e         kind;
  logic [EW-1:0]  nxt;

  assign sgn  = elem_in[EW-1];
  assign expo = elem_in[EW-2 -: EXW];
  assign mant = elem_in[MW-1:0];
  assign kind = classify(expo, shift);

  assign is_under   = (kind == EK_UNDER);
  assign is_special = (kind == EK_SPECIAL);

  always_comb begin
    unique case (kind)
      EK_SPECIAL: nxt = elem_in;
      EK_NORMAL:  nxt = {sgn, exp_reduce(expo, shift), mant};
      default:    nxt = {sgn, {(EW-1){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      elem_out <= '0;
    else
      elem_out <= nxt;
  end

endmodule

// File: rtl/fexm_unit.sv
module fexm_unit
  import fexm_pkg::*;
#(
  parameter bit FP32_ELEM = 1'b0,
  parameter int LANES     = 4,
  localparam int EW       = FP32_ELEM ? 32 : 16,
  localparam int VW       = LANES * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   in_x,
  input  logic [VW-1:0] in_vec,
  output logic          out_valid,
  output logic [VW-1:0] out_vec
);

  localparam int XDEPTH = 3;  // stages of the argument path

  // internal events, named for the checker
  logic signed [XW-1:0] s1_xc;
  logic                 s3_valid;
  logic [SHW-1:0]       s3_shift;
  logic [VW-1:0]        d3_vec;
  logic [LANES-1:0]     lane_uf;
  logic [LANES-1:0]     lane_spec;

  fexm_shift_path u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_x     ($signed(in_x)),
    .s1_xc    (s1_xc),
    .s3_valid (s3_valid),
    .s3_shift (s3_shift)
  );

  fexm_vec_delay #(.W(VW), .DEPTH(XDEPTH)) u_vdly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (in_vec),
    .d_out (d3_vec)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fexm_lane #(.EW(EW)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .elem_in    (d3_vec[i*EW +: EW]),
      .shift      (s3_shift),
      .is_under   (lane_uf[i]),
      .is_special (lane_spec[i]),
      .elem_out   (out_vec[i*EW +: EW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else
      out_valid <= s3_valid;
  end

endmodule

// File: rtl/fexm_unit_chk.sv
module fexm_unit_chk #(
  parameter int LANES = 4,
  parameter int EW    = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [15:0]           in_x,
  input logic                  out_valid,
  input logic [LANES*EW-1:0]   out_vec,
  input logic signed [15:0]    s1_xc,
  input logic                  s3_valid,
  input logic [4:0]            s3_shift,
  input logic [LANES*EW-1:0]   d3_vec,
  input logic [LANES-1:0]      lane_uf,
  input logic [LANES-1:0]      lane_spec
);

  logic [2:0] live_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      live_cnt <= '0;
    else if (live_cnt != 3'd4)
      live_cnt <= live_cnt + 3'd1;
  end

  assert_pos_clip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $signed(in_x) > 0) |=> (s1_xc == 16'sd0));

  assert_neg_clip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $signed(in_x) < -16'sd15360) |=> (s1_xc == -16'sd15360));

  assert_shift_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s3_valid |-> (s3_shift <= 5'd22));

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  for (genvar i = 0; i < LANES; i++) begin : g_lchk
    assert_underflow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s3_valid && lane_uf[i]) |=>
        (out_vec[i*EW +: EW-1] == '0) && (out_vec[i*EW+EW-1] == $past(d3_vec[i*EW+EW-1])));

    assert_special_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s3_valid && lane_spec[i]) |=> (out_vec[i*EW +: EW] == $past(d3_vec[i*EW +: EW])));
  end

endmodule

bind fexm_unit fexm_unit_chk #(.LANES(LANES), .EW(EW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_x      (in_x),
  .out_valid (out_valid),
  .out_vec   (out_vec),
  .s1_xc     (s1_xc),
  .s3_valid  (s3_valid),
  .s3_shift  (s3_shift),
  .d3_vec    (d3_vec),
  .lane_uf   (lane_uf),
  .lane_spec (lane_spec)
);

// File: tb/fexm_unit_tb.sv
module fexm_unit_tb;

  localparam int LANES = 4;
  localparam int EW    = 16;
  localparam int VW    = LANES * EW;
  localparam int NCYC  = 1024;
  localparam int LAT   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [15:0]   in_x = '0;
  logic [VW-1:0] in_vec = '0;
  logic          out_valid;
  logic [VW-1:0] out_vec;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  logic          v_hist [NCYC];
  logic [15:0]   x_hist [NCYC];
  logic [VW-1:0] e_hist [NCYC];

  always #4 clk = ~clk;  // 125 MHz

  fexm_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
  );

  function automatic int fdiv(int a, int b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  function automatic int model_shift(logic [15:0] xr);
    int xi, xc, t;
    xi = int'($signed(xr));
    xc = (xi > 0) ? 0 : ((xi < -15360) ? -15360 : xi);
    t  = xc + fdiv(xc, 2) - fdiv(xc, 16);
    return -fdiv(t + 512, 1024);
  endfunction

  function automatic logic [EW-1:0] model_lane(logic [EW-1:0] el, int sh);
    int e;
    e = int'(el[14:7]);
    if (e == 255) return el;
    if (e == 0 || e <= sh) return {el[15], 15'b0};
    return {el[15], 8'(e - sh), el[6:0]};
  endfunction

  function automatic logic [EW-1:0] mk(bit s, int e, int m);
    return {s, 8'(e), 7'(m)};
  endfunction

  function automatic logic [EW-1:0] rnd_lane();
    int r;
    r = int'($urandom % 10);
    if (r == 0) return mk(1'(($urandom)), 255, int'($urandom % 128));
    if (r == 1) return mk(1'(($urandom)), 0, int'($urandom % 128));
    if (r == 2) return mk(1'(($urandom)), 1 + int'($urandom % 23), int'($urandom % 128));
    return mk(1'(($urandom)), 1 + int'($urandom % 254), int'($urandom % 128));
  endfunction

  function automatic logic [15:0] rnd_x();
    int r;
    r = int'($urandom % 8);
    if (r == 0) return 16'(1 + int'($urandom % 32767));
    if (r == 1) return 16'(-15361 - int'($urandom % 17408));
    return 16'(-int'($urandom % 15361));
  endfunction

  task automatic put(int c, bit v, logic [15:0] x, logic [VW-1:0] vec);
    v_hist[c] = v;
    x_hist[c] = x;
    e_hist[c] = vec;
    in_valid  = v;
    in_x      = x;
    in_vec    = vec;
  endtask

  task automatic judge(int idx);
    int sh;
    int xi;
    logic [EW-1:0] got, exp_l, src;
    string tag;
    checks++;
    if (out_valid !== v_hist[idx]) begin
      bad++;
      $display("FAIL R7 beat %0d: out_valid=%0b expected %0b", idx, out_valid, v_hist[idx]);
    end
    if (!v_hist[idx]) return;
    sh = model_shift(x_hist[idx]);
    xi = int'($signed(x_hist[idx]));
    for (int i = 0; i < LANES; i++) begin
      src   = e_hist[idx][i*EW +: EW];
      got   = out_vec[i*EW +: EW];
      exp_l = model_lane(src, sh);
      if (idx == 4)                  tag = "R9";
      else if (src[14:7] == 8'hff)   tag = "R5";
      else if (src[14:7] == 8'h00)   tag = "R6";
      else if (int'(src[14:7]) <= sh) tag = "R4";
      else if (xi > 0)               tag = "R1";
      else if (xi < -15360)          tag = "R2";
      else                           tag = "R3";
      checks++;
      if (got !== exp_l) begin
        bad++;
        $display("FAIL %s beat %0d lane %0d: got %h expected %h", tag, idx, i, got, exp_l);
      end
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'd20251219));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs quiet during reset
    checks++;
    if (out_valid !== 1'b0 || out_vec !== '0) begin
      bad++;
      $display("FAIL R8 in reset: out_valid=%0b out_vec=%h expected 0/0", out_valid, out_vec);
    end
    rst_n = 1'b1;
    for (int c = 0; c < NCYC + LAT; c++) begin
      @(negedge clk);
      if (c == 0) begin
        checks++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
          bad++;
          $display("FAIL R8 after reset: out_valid=%0b out_vec=%h expected 0/0", out_valid, out_vec);
        end
      end
      if (c >= LAT) judge(c - LAT);
      if (c >= NCYC) begin
        in_valid = 1'b0;
      end else begin
        case (c)
          0: put(c, 1'b1, 16'sd0,
                 {mk(1, 254, 3), mk(0, 1, 1), mk(1, 200, 127), mk(0, 127, 5)});
          1: put(c, 1'b1, 16'sd1024,   // R1: +1.0 clipped to 0
                 {mk(1, 254, 3), mk(0, 1, 1), mk(1, 200, 127), mk(0, 127, 5)});
          2: put(c, 1'b1, 16'h8000,    // R2 with R4: shift 22
                 {mk(0, 255, 5), mk(1, 255, 0), mk(0, 23, 9), mk(1, 22, 44)});
          3: put(c, 1'b1, -16'sd1024,  // R3: x=-1.0 gives shift 1
                 {mk(0, 0, 3), mk(1, 0, 0), mk(0, 2, 17), mk(1, 1, 100)});
          4: put(c, 1'b1, -16'sd15360, // R9: mixed kinds, shift 22
                 {mk(1, 255, 0), mk(0, 0, 0), mk(1, 22, 1), mk(0, 150, 77)});
          5: put(c, 1'b0, 16'sd0, '0);
          6: put(c, 1'b1, -16'sd1,     // rounds to shift 0
                 {mk(0, 2, 2), mk(1, 9, 9), mk(0, 100, 3), mk(1, 77, 1)});
          default: begin
            logic [VW-1:0] vec;
            for (int i = 0; i < LANES; i++) vec[i*EW +: EW] = rnd_lane();
            put(c, ($urandom % 4) != 0, rnd_x(), vec);
          end
        endcase
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule